// File: doc/BRIEF.md
# Delay Tap Debug Adjust Controller

This block steers the programmable input-delay lines of a DDR read-capture interface from a debug path. The delay lines fall into three groups: data lanes, strobe lanes and strobe-gate lanes. For every lane, the block emits single-cycle increment and decrement strobes that drive the delay element. It also keeps a 6-bit tap count per lane, which a debugger reads back to see where each line currently sits.

One set of controls can move three different scopes by one tap per clock cycle: every line in all three groups, every line of one group, or one indexed lane of one group. Moves are blocked until calibration has finished, so that calibration in progress is never disturbed. All logic runs on the half-rate interface clock. A parameter removes the whole adjustment path; the strobes and counts then stay at zero.

Top module: `tap_debug_ctrl`

## Requirements
- R1: A synchronous active-high reset clears every lane's tap count to 0 and deasserts every increment and decrement strobe.
- R2: Each clock edge at which a request is high moves each targeted lane by exactly one tap. The strobe and the updated count appear after that same edge. A request held for N cycles moves the lane N taps.
- R3: The global up/down pair targets every lane of the data, strobe and strobe-gate groups at once.
- R4: When a group's select-all flag is 1, that group's up/down pair targets every lane of that group and no lane of the other groups.
- R5: When a group's select-all flag is 0, the group's pair targets only the lane whose number equals the group's index input. The index is a binary lane number, with lane 0 on bits [TAP_W-1:0] of the flat tap output.
- R6: An index value at or beyond the group's lane count targets no lane.
- R7: If a lane is targeted by an up request and a down request in the same cycle, from any combination of global and group pairs, that lane does not move and emits no strobe.
- R8: Tap counts saturate at 0 and at 63. A request that would pass a limit produces no strobe and leaves the count unchanged.
- R9: While the calibration-done input is 0, all requests are ignored: no strobe is produced and no count changes.
- R10: With ADJ_EN = 0, all strobes and all tap counts are constantly 0 whatever the inputs.
- R11: A lane never asserts its increment and decrement strobes in the same cycle, and a strobe always coincides with a one-tap change of that lane's count in the strobe's direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Half-rate interface clock |
| rst | input | 1 | Synchronous active-high reset |
| cal_done | input | 1 | Calibration finished; enables debug moves |
| all_up | input | 1 | Increment every lane of every group |
| all_dn | input | 1 | Decrement every lane of every group |
| dq_up | input | 1 | Data group increment request |
| dq_dn | input | 1 | Data group decrement request |
| dq_all | input | 1 | Data group: apply to all lanes |
| dq_idx | input | idx_w(DQ_LANES) | Data group lane index |
| dqs_up | input | 1 | Strobe group increment request |
| dqs_dn | input | 1 | Strobe group decrement request |
| dqs_all | input | 1 | Strobe group: apply to all lanes |
| dqs_idx | input | idx_w(DQS_LANES) | Strobe group lane index |
| gate_up | input | 1 | Gate group increment request |
| gate_dn | input | 1 | Gate group decrement request |
| gate_all | input | 1 | Gate group: apply to all lanes |
| gate_idx | input | idx_w(GATE_LANES) | Gate group lane index |
| dq_inc | output | DQ_LANES | Per-lane data delay increment strobe |
| dq_dec | output | DQ_LANES | Per-lane data delay decrement strobe |
| dq_taps | output | DQ_LANES*TAP_W | Data lane tap counts, lane 0 lowest |
| dqs_inc | output | DQS_LANES | Per-lane strobe delay increment strobe |
| dqs_dec | output | DQS_LANES | Per-lane strobe delay decrement strobe |
| dqs_taps | output | DQS_LANES*TAP_W | Strobe lane tap counts |
| gate_inc | output | GATE_LANES | Per-lane gate delay increment strobe |
| gate_dec | output | GATE_LANES | Per-lane gate delay decrement strobe |
| gate_taps | output | GATE_LANES*TAP_W | Gate lane tap counts |

## Verification
The bench uses a small configuration of 6 data, 2 strobe and 3 gate lanes, and sweeps each group's index over every encodable value. Because the data and gate index ranges include codes past the last lane, the sweep shows whether out-of-range codes alias onto real lanes. Single pulses show whether exactly one lane moved. Select-all and global moves show whether the move spilled into neighbouring groups. Held requests of 70 cycles in each direction show whether the counts saturate or wrap. Opposing global and group requests show whether the cancellation is resolved per lane rather than per group. A deterministic pseudo-random mix of all controls, including cal_done low, is compared every cycle against an arithmetic model. A second copy with adjustment disabled must stay at zero throughout.

// File: rtl/tap_debug_pkg.sv
package tap_debug_pkg;

    typedef enum logic [1:0] {
        MV_HOLD = 2'b00,
        MV_UP   = 2'b01,
        MV_DOWN = 2'b10
    } tap_move_e;

    typedef struct packed {
        logic up;
        logic dn;
    } tap_req_t;

    // Index width for a group; at least one bit.
    function automatic int idx_w(input int lanes);
        return (lanes <= 1) ? 1 : $clog2(lanes);
    endfunction

    // Resolve a request pair against the current count and its ceiling.
    function automatic tap_move_e resolve_move(
        input tap_req_t   req,
        input logic [7:0] taps,
        input logic [7:0] ceiling
    );
        if (req.up && !req.dn && (taps != ceiling))
            return MV_UP;
        if (req.dn && !req.up && (taps != 8'd0))
            return MV_DOWN;
        return MV_HOLD;
    endfunction

endpackage

// File: rtl/tap_lane_sel.sv
module tap_lane_sel
    import tap_debug_pkg::*;
#(
    parameter int LANES = 8,
    localparam int IW   = idx_w(LANES)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cal_done,
    input  logic            glob_up,
    input  logic            glob_dn,
    input  logic            grp_up,
    input  logic            grp_dn,
    input  logic            grp_all,
    input  logic [IW-1:0]   grp_idx,
    output tap_req_t        lane_req [LANES]
);

    logic [LANES-1:0] hit;

    for (genvar i = 0; i < LANES; i++) begin : g_hit
        assign hit[i] = grp_all || (grp_idx == IW'(i));
        always_comb begin
            lane_req[i].up = cal_done && (glob_up || (grp_up && hit[i]));
            lane_req[i].dn = cal_done && (glob_dn || (grp_dn && hit[i]));
        end
    end

    logic [LANES-1:0] any_req;
    for (genvar i = 0; i < LANES; i++) begin : g_any
        assign any_req[i] = lane_req[i].up || lane_req[i].dn;
    end

    // R6: an index past the last lane, with no select-all and no global request, reaches no lane
    a_r6_no_alias: assert property (@(posedge clk) disable iff (rst)
        (!grp_all && (int'(grp_idx) >= LANES) && !glob_up && !glob_dn) |-> (any_req == '0));

    // R5: a group request with select-all clear never reaches more than one lane
    a_r5_single_lane: assert property (@(posedge clk) disable iff (rst)
        (!grp_all && !glob_up && !glob_dn) |-> $onehot0(any_req));

endmodule

// File: rtl/tap_lane_ctr.sv
module tap_lane_ctr
    import tap_debug_pkg::*;
#(
    parameter int TAP_W = 6,
    localparam logic [TAP_W-1:0] TAP_MAX = {TAP_W{1'b1}}
) (
    input  logic             clk,
    input  logic             rst,
    input  tap_req_t         req,
    output logic             inc,
    output logic             dec,
    output logic [TAP_W-1:0] taps
);

    typedef struct packed {
        logic             inc;
        logic             dec;
        logic [TAP_W-1:0] taps;
    } lane_state_t;

    lane_state_t cur, nxt;
    tap_move_e   mv;

    always_comb begin
        mv       = resolve_move(req, 8'(taps), 8'(TAP_MAX));
        nxt.inc  = (mv == MV_UP);
        nxt.dec  = (mv == MV_DOWN);
        nxt.taps = cur.taps;
        unique case (mv)
            MV_UP:   nxt.taps = cur.taps + TAP_W'(1);
            MV_DOWN: nxt.taps = cur.taps - TAP_W'(1);
            default: nxt.taps = cur.taps;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) cur <= '0;
        else     cur <= nxt;
    end

    assign inc  = cur.inc;
    assign dec  = cur.dec;
    assign taps = cur.taps;

    // R11: never both strobes at once
    a_r11_one_strobe: assert property (@(posedge clk) disable iff (rst)
        !(inc && dec));

    // R11: an increment strobe comes with a one-tap rise
    a_r11_inc_step: assert property (@(posedge clk) disable iff (rst)
        inc |-> (taps == $past(taps) + TAP_W'(1)));

    // R11: a decrement strobe comes with a one-tap fall
    a_r11_dec_step: assert property (@(posedge clk) disable iff (rst)
        dec |-> (taps == $past(taps) - TAP_W'(1)));

    // R8: without a strobe the count holds, so it never wraps
    a_r8_hold_no_strobe: assert property (@(posedge clk) disable iff (rst)
        (!inc && !dec) |-> $stable(taps));

    // R8: a full count is never incremented again
    a_r8_ceiling: assert property (@(posedge clk) disable iff (rst)
        ($past(taps) == TAP_MAX) |-> !inc);

endmodule

// File: rtl/tap_group_bank.sv
module tap_group_bank
    import tap_debug_pkg::*;
#(
    parameter int LANES = 8,
    parameter int TAP_W = 6,
    localparam int IW   = idx_w(LANES)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   cal_done,
    input  logic                   glob_up,
    input  logic                   glob_dn,
    input  logic                   grp_up,
    input  logic                   grp_dn,
    input  logic                   grp_all,
    input  logic [IW-1:0]          grp_idx,
    output logic [LANES-1:0]       inc,
    output logic [LANES-1:0]       dec,
    output logic [LANES*TAP_W-1:0] taps
);

    tap_req_t req [LANES];

    tap_lane_sel #(.LANES(LANES)) u_sel (
        .clk      (clk),
        .rst      (rst),
        .cal_done (cal_done),
        .glob_up  (glob_up),
        .glob_dn  (glob_dn),
        .grp_up   (grp_up),
        .grp_dn   (grp_dn),
        .grp_all  (grp_all),
        .grp_idx  (grp_idx),
        .lane_req (req)
    );

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        tap_lane_ctr #(.TAP_W(TAP_W)) u_ctr (
            .clk  (clk),
            .rst  (rst),
            .req  (req[i]),
            .inc  (inc[i]),
            .dec  (dec[i]),
            .taps (taps[i*TAP_W +: TAP_W])
        );
    end

    // R9: before calibration ends, no lane of the group moves
    a_r9_wait_cal: assert property (@(posedge clk) disable iff (rst)
        !cal_done |=> ((inc == '0) && (dec == '0) && $stable(taps)));

endmodule

// File: rtl/tap_debug_ctrl.sv
module tap_debug_ctrl
    import tap_debug_pkg::*;
#(
    parameter int DQ_LANES   = 32,
    parameter int DQS_LANES  = 4,
    parameter int GATE_LANES = 4,
    parameter int TAP_W      = 6,
    parameter bit ADJ_EN     = 1'b1
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            cal_done,
    input  logic                            all_up,
    input  logic                            all_dn,
    input  logic                            dq_up,
    input  logic                            dq_dn,
    input  logic                            dq_all,
    input  logic [idx_w(DQ_LANES)-1:0]      dq_idx,
    input  logic                            dqs_up,
    input  logic                            dqs_dn,
    input  logic                            dqs_all,
    input  logic [idx_w(DQS_LANES)-1:0]     dqs_idx,
    input  logic                            gate_up,
    input  logic                            gate_dn,
    input  logic                            gate_all,
    input  logic [idx_w(GATE_LANES)-1:0]    gate_idx,
    output logic [DQ_LANES-1:0]             dq_inc,
    output logic [DQ_LANES-1:0]             dq_dec,
    output logic [DQ_LANES*TAP_W-1:0]       dq_taps,
    output logic [DQS_LANES-1:0]            dqs_inc,
    output logic [DQS_LANES-1:0]            dqs_dec,
    output logic [DQS_LANES*TAP_W-1:0]      dqs_taps,
    output logic [GATE_LANES-1:0]           gate_inc,
    output logic [GATE_LANES-1:0]           gate_dec,
    output logic [GATE_LANES*TAP_W-1:0]     gate_taps
);

    if (ADJ_EN) begin : g_adj
        tap_group_bank #(.LANES(DQ_LANES), .TAP_W(TAP_W)) u_dq (
            .clk(clk), .rst(rst), .cal_done(cal_done),
            .glob_up(all_up), .glob_dn(all_dn),
            .grp_up(dq_up), .grp_dn(dq_dn), .grp_all(dq_all), .grp_idx(dq_idx),
            .inc(dq_inc), .dec(dq_dec), .taps(dq_taps)
        );
        tap_group_bank #(.LANES(DQS_LANES), .TAP_W(TAP_W)) u_dqs (
            .clk(clk), .rst(rst), .cal_done(cal_done),
            .glob_up(all_up), .glob_dn(all_dn),
            .grp_up(dqs_up), .grp_dn(dqs_dn), .grp_all(dqs_all), .grp_idx(dqs_idx),
            .inc(dqs_inc), .dec(dqs_dec), .taps(dqs_taps)
        );
        tap_group_bank #(.LANES(GATE_LANES), .TAP_W(TAP_W)) u_gate (
            .clk(clk), .rst(rst), .cal_done(cal_done),
            .glob_up(all_up), .glob_dn(all_dn),
            .grp_up(gate_up), .grp_dn(gate_dn), .grp_all(gate_all), .grp_idx(gate_idx),
            .inc(gate_inc), .dec(gate_dec), .taps(gate_taps)
        );

        // R3: a lone global increment after calibration raises lane 0 of every group unless it was full
        a_r3_global_reach: assert property (@(posedge clk) disable iff (rst)
            (cal_done && all_up && !all_dn && !dq_dn && !dqs_dn && !gate_dn)
            |=> ((dq_inc[0]   || $past(dq_taps[TAP_W-1:0])   == {TAP_W{1'b1}}) &&
                 (dqs_inc[0]  || $past(dqs_taps[TAP_W-1:0])  == {TAP_W{1'b1}}) &&
                 (gate_inc[0] || $past(gate_taps[TAP_W-1:0]) == {TAP_W{1'b1}})));
    end else begin : g_off
        assign dq_inc    = '0;
        assign dq_dec    = '0;
        assign dq_taps   = '0;
        assign dqs_inc   = '0;
        assign dqs_dec   = '0;
        assign dqs_taps  = '0;
        assign gate_inc  = '0;
        assign gate_dec  = '0;
        assign gate_taps = '0;
    end

endmodule

// File: tb/test_tap_debug_ctrl.sv
`timescale 1ns/1ps
module test_tap_debug_ctrl;

    localparam int NDQ = 6, NDQS = 2, NGT = 3, TW = 6;
    localparam int NL  = NDQ + NDQS + NGT;
    localparam int MAXT = 63;

    logic clk = 0;
    logic rst = 1;
    always #5 clk = ~clk;

    logic cal_done = 0, all_up = 0, all_dn = 0;
    logic g_up [3], g_dn [3], g_all [3];
    int   g_idx [3];
    logic [2:0] dq_idx;
    logic [0:0] dqs_idx;
    logic [1:0] gate_idx;
    assign dq_idx   = 3'(g_idx[0]);
    assign dqs_idx  = 1'(g_idx[1]);
    assign gate_idx = 2'(g_idx[2]);

    logic [NDQ-1:0]     dq_inc, dq_dec, o_dq_inc, o_dq_dec;
    logic [NDQ*TW-1:0]  dq_taps, o_dq_taps;
    logic [NDQS-1:0]    dqs_inc, dqs_dec, o_dqs_inc, o_dqs_dec;
    logic [NDQS*TW-1:0] dqs_taps, o_dqs_taps;
    logic [NGT-1:0]     gate_inc, gate_dec, o_gate_inc, o_gate_dec;
    logic [NGT*TW-1:0]  gate_taps, o_gate_taps;

    tap_debug_ctrl #(.DQ_LANES(NDQ), .DQS_LANES(NDQS), .GATE_LANES(NGT), .TAP_W(TW), .ADJ_EN(1'b1))
    i_tap_debug_ctrl (
        .clk(clk), .rst(rst), .cal_done(cal_done), .all_up(all_up), .all_dn(all_dn),
        .dq_up(g_up[0]), .dq_dn(g_dn[0]), .dq_all(g_all[0]), .dq_idx(dq_idx),
        .dqs_up(g_up[1]), .dqs_dn(g_dn[1]), .dqs_all(g_all[1]), .dqs_idx(dqs_idx),
        .gate_up(g_up[2]), .gate_dn(g_dn[2]), .gate_all(g_all[2]), .gate_idx(gate_idx),
        .dq_inc(dq_inc), .dq_dec(dq_dec), .dq_taps(dq_taps),
        .dqs_inc(dqs_inc), .dqs_dec(dqs_dec), .dqs_taps(dqs_taps),
        .gate_inc(gate_inc), .gate_dec(gate_dec), .gate_taps(gate_taps)
    );

    tap_debug_ctrl #(.DQ_LANES(NDQ), .DQS_LANES(NDQS), .GATE_LANES(NGT), .TAP_W(TW), .ADJ_EN(1'b0))
    i_tap_debug_ctrl_off (
        .clk(clk), .rst(rst), .cal_done(cal_done), .all_up(all_up), .all_dn(all_dn),
        .dq_up(g_up[0]), .dq_dn(g_dn[0]), .dq_all(g_all[0]), .dq_idx(dq_idx),
        .dqs_up(g_up[1]), .dqs_dn(g_dn[1]), .dqs_all(g_all[1]), .dqs_idx(dqs_idx),
        .gate_up(g_up[2]), .gate_dn(g_dn[2]), .gate_all(g_all[2]), .gate_idx(gate_idx),
        .dq_inc(o_dq_inc), .dq_dec(o_dq_dec), .dq_taps(o_dq_taps),
        .dqs_inc(o_dqs_inc), .dqs_dec(o_dqs_dec), .dqs_taps(o_dqs_taps),
        .gate_inc(o_gate_inc), .gate_dec(o_gate_dec), .gate_taps(o_gate_taps)
    );

    int checks = 0, errors = 0;
    int exp_cnt [NL];
    bit exp_inc [NL], exp_dec [NL];

    function automatic int grp_of(input int l);
        return (l < NDQ) ? 0 : (l < NDQ + NDQS) ? 1 : 2;
    endfunction
    function automatic int loc_of(input int l);
        return (l < NDQ) ? l : (l < NDQ + NDQS) ? l - NDQ : l - NDQ - NDQS;
    endfunction

    function automatic int act_cnt(input int l);
        int k = loc_of(l);
        case (grp_of(l))
            0: return int'(dq_taps[k*TW +: TW]);
            1: return int'(dqs_taps[k*TW +: TW]);
            default: return int'(gate_taps[k*TW +: TW]);
        endcase
    endfunction
    function automatic bit act_inc(input int l);
        int k = loc_of(l);
        case (grp_of(l))
            0: return dq_inc[k];
            1: return dqs_inc[k];
            default: return gate_inc[k];
        endcase
    endfunction
    function automatic bit act_dec(input int l);
        int k = loc_of(l);
        case (grp_of(l))
            0: return dq_dec[k];
            1: return dqs_dec[k];
            default: return gate_dec[k];
        endcase
    endfunction

    // Arithmetic model of one clock edge, from the requirements.
    task automatic model_edge();
        for (int l = 0; l < NL; l++) begin
            int g = grp_of(l);
            bit hit = g_all[g] || (g_idx[g] == loc_of(l));
            bit up  = all_up || (g_up[g] && hit);
            bit dn  = all_dn || (g_dn[g] && hit);
            exp_inc[l] = 0;
            exp_dec[l] = 0;
            if (cal_done && up && !dn && exp_cnt[l] < MAXT) begin
                exp_cnt[l]++; exp_inc[l] = 1;
            end else if (cal_done && dn && !up && exp_cnt[l] > 0) begin
                exp_cnt[l]--; exp_dec[l] = 1;
            end
        end
    endtask

    task automatic compare(input string tag);
        for (int g = 0; g < 3; g++) begin
            bit bad = 0;
            checks++;
            for (int l = 0; l < NL; l++) begin
                if (grp_of(l) == g &&
                    (act_cnt(l) != exp_cnt[l] || act_inc(l) != exp_inc[l] || act_dec(l) != exp_dec[l])) begin
                    bad = 1;
                    $display("FAIL %s lane %0d: taps=%0d inc=%0d dec=%0d expected taps=%0d inc=%0d dec=%0d",
                             tag, l, act_cnt(l), act_inc(l), act_dec(l), exp_cnt[l], exp_inc[l], exp_dec[l]);
                end
            end
            if (bad) errors++;
        end
        checks++;
        for (int l = 0; l < NL; l++) begin
            if (act_inc(l) && act_dec(l)) begin
                errors++;
                $display("FAIL R11 lane %0d: inc=1 dec=1 expected at most one", l);
                break;
            end
        end
        checks++;
        if ((o_dq_inc | o_dq_dec) != '0 || (o_dqs_inc | o_dqs_dec) != '0 || (o_gate_inc | o_gate_dec) != '0 ||
            o_dq_taps != '0 || o_dqs_taps != '0 || o_gate_taps != '0) begin
            errors++;
            $display("FAIL R10 disabled copy: dq_taps=%h dqs_taps=%h gate_taps=%h expected all 0",
                     o_dq_taps, o_dqs_taps, o_gate_taps);
        end
    endtask

    task automatic clear_req();
        all_up = 0; all_dn = 0;
        for (int g = 0; g < 3; g++) begin
            g_up[g] = 0; g_dn[g] = 0; g_all[g] = 0; g_idx[g] = 0;
        end
    endtask

    // Requests are set by the caller after a falling edge; one rising edge is then checked.
    task automatic step(input string tag);
        @(posedge clk);
        model_edge();
        #1;
        compare(tag);
        @(negedge clk);
    endtask

    bit done = 0;
    initial begin
        #1500000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    int idx_lim [3] = '{8, 2, 4};

    initial begin
        clear_req();
        for (int l = 0; l < NL; l++) begin exp_cnt[l] = 0; exp_inc[l] = 0; exp_dec[l] = 0; end
        all_up = 1; g_up[0] = 1; g_all[0] = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        compare("R1 reset state");
        rst = 0;
        clear_req();

        // R9: requests before calibration completes
        all_up = 1;
        step("R9 global up before cal_done");
        clear_req(); g_up[0] = 1; g_all[0] = 1;
        step("R9 group up before cal_done");
        clear_req();
        cal_done = 1;

        // R3 single global pulse, R2 held for 4 cycles
        all_up = 1;
        step("R3 global up pulse");
        for (int i = 0; i < 4; i++) step("R2 held global up");
        all_up = 0;
        step("R2 idle after release");

        // R4 select-all per group, both directions
        for (int g = 0; g < 3; g++) begin
            clear_req(); g_all[g] = 1; g_up[g] = 1;
            step("R4 group select-all up");
            step("R4 group select-all up");
            g_up[g] = 0; g_dn[g] = 1;
            step("R4 group select-all down");
        end
        clear_req();

        // R5/R6 index sweep over every encodable value
        for (int g = 0; g < 3; g++) begin
            for (int k = 0; k < idx_lim[g]; k++) begin
                clear_req(); g_idx[g] = k; g_up[g] = 1;
                step(k < ((g == 0) ? NDQ : (g == 1) ? NDQS : NGT) ? "R5 indexed up" : "R6 index beyond lanes up");
                g_up[g] = 0; g_dn[g] = 1;
                step(k < ((g == 0) ? NDQ : (g == 1) ? NDQS : NGT) ? "R5 indexed down" : "R6 index beyond lanes down");
            end
        end
        clear_req();

        // R7 cancellation
        all_up = 1; all_dn = 1;
        step("R7 global up and down");
        clear_req(); g_all[0] = 1; g_up[0] = 1; g_dn[0] = 1;
        step("R7 group up and down");
        clear_req(); all_up = 1; g_idx[2] = 1; g_dn[2] = 1;
        step("R7 global up against indexed down");
        clear_req();

        // R8 saturation both ways
        all_up = 1;
        for (int i = 0; i < 70; i++) step("R8 ceiling at 63");
        clear_req(); all_dn = 1;
        for (int i = 0; i < 70; i++) step("R8 floor at 0");
        clear_req();

        // Mixed deterministic stimulus
        begin
            int unsigned s = 32'h1234_5678;
            for (int i = 0; i < 400; i++) begin
                s = s * 32'd1103515245 + 32'd12345;
                cal_done = (s[30:28] != 3'd0);
                all_up = (s[27:25] == 3'd1);
                all_dn = (s[24:22] == 3'd2);
                for (int g = 0; g < 3; g++) begin
                    g_up[g]  = s[g*3+1];
                    g_dn[g]  = s[g*3+2] & s[20];
                    g_all[g] = (s[g*3+3] & s[21]);
                    g_idx[g] = int'(s[g*2+12 +: 2]) % idx_lim[g];
                end
                step("R2 mixed pattern");
            end
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule